// File: doc/BRIEF.md
# Depth-Cue Color Interpolation Stage

This fixed-point stage blends a lit color toward a far color by a signed interpolation factor. A start pulse captures a 32-bit color word (red, green and blue bytes plus a code byte), three signed 16-bit intermediate values, three signed 32-bit far-color components, a signed 16-bit factor, a shift-format bit and a low-limit bit. The stage then runs three arithmetic phases on successive clock cycles and pushes a packed, saturated 8-bit color.

The first phase forms a base accumulator per channel from the color byte and the intermediate value. The second phase takes the scaled far color minus that base, optionally shifts it right by 12, and clamps it into the intermediate register. The third phase multiplies the clamped difference by the factor, adds the base, shifts again, and clamps once more under the low-limit rule. Because the factor acts on a clamped difference, the blend is not an exact linear interpolation. A final cycle writes the output color and the saturation flags, and a one-cycle done pulse follows.

Top module: `dq_interp`

## Requirements
- R1: After reset, busy and done are 0 and color_out, flags, res_x, res_y and res_z are all zero.
- R2: In the first phase each channel's base accumulator is (zero-extended color byte + signed intermediate) shifted left by 4, with no right shift. Red is color_in[7:0], green is color_in[15:8] and blue is color_in[23:16].
- R3: In the second phase each intermediate becomes ((far component << 12) - base) shifted arithmetically right by 12 when sf is 1 and not shifted when sf is 0. It is then clamped to -32768..32767 whatever lm is.
- R4: In the third phase each accumulator becomes (intermediate * factor + base), shifted arithmetically right by 12 when sf is 1 and kept to 32 bits. The intermediate (res_x/y/z) is that accumulator clamped to 0..32767 when lm is 1, or to -32768..32767 when lm is 0.
- R5: Each pushed color byte is the accumulator shifted arithmetically right by 4 and then saturated to 0..255. color_out packs red in [7:0], green in [15:8], blue in [23:16], and color_in[31:24] in [31:24].
- R6: flags[2:0] record, per channel (bit 0 red, 1 green, 2 blue), a clamp in phase 2 or phase 3. flags[5:3] record, per channel in the same order, a saturation of the pushed byte. flags[6] is the OR of flags[5:0]. All flags clear when an operation is accepted.
- R7: A start seen while idle is accepted on that edge. busy is 1 for the next three cycles. done is a single-cycle pulse that rises on the fourth edge counted from acceptance, when the results also appear.
- R8: A start seen while busy is ignored and does not change the results of the operation in progress. Inputs other than start are sampled only on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| color_in | input | 32 | Color bytes red, green, blue, code (low to high) |
| ir_x | input | 16 | Signed intermediate, red channel |
| ir_y | input | 16 | Signed intermediate, green channel |
| ir_z | input | 16 | Signed intermediate, blue channel |
| far_r | input | 32 | Signed far color, red |
| far_g | input | 32 | Signed far color, green |
| far_b | input | 32 | Signed far color, blue |
| factor | input | 16 | Signed interpolation factor |
| sf | input | 1 | Shift-format: 1 selects a right shift by 12 |
| lm | input | 1 | Low limit: 1 clamps the final intermediates at 0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| color_out | output | 32 | Pushed packed color |
| res_x | output | 16 | Final intermediate, red |
| res_y | output | 16 | Final intermediate, green |
| res_z | output | 16 | Final intermediate, blue |
| flags | output | 7 | Saturation flags and error summary |

## Verification
The assertions check on every cycle that the phases are ordered and mutually exclusive, that done is a one-cycle pulse following the push, that flags clear on acceptance and that the summary bit agrees with the channel bits. They also check that a low-limited result is never negative and that a saturated byte sits at 0 or 255. The arithmetic itself can only be shown by the bench's scenarios. These include the double clamp on a saturated difference, negative and zero factors, both shift formats, the code byte passing through, and a start that arrives mid-operation.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int COL_W  = 8;
  localparam int IR_W   = 16;
  localparam int MAC_W  = 32;
  localparam int FAR_W  = 32;
  localparam int FRAC   = 12;
  localparam int GUARD  = 4;
  localparam int WIDE_W = 64;
  localparam int LANES  = 3;

  typedef logic signed [WIDE_W-1:0] wide_t;

  localparam wide_t IR_MAX  = (wide_t'(1) <<< (IR_W-1)) - wide_t'(1);
  localparam wide_t IR_MIN  = -(wide_t'(1) <<< (IR_W-1));
  localparam wide_t COL_MAX = (wide_t'(1) <<< COL_W) - wide_t'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_DIFF, ST_BLEND, ST_PUSH} phase_t;

  typedef struct packed {
    logic                   sat;
    logic signed [IR_W-1:0] val;
  } ir_clamp_t;

  typedef struct packed {
    logic             sat;
    logic [COL_W-1:0] val;
  } col_clamp_t;

  // Phase 1: (color + intermediate) scaled by the guard bits
  function automatic logic signed [MAC_W-1:0] base_acc(
      input logic [COL_W-1:0] c, input logic signed [IR_W-1:0] ir);
    wide_t s;
    s = wide_t'({1'b0, c}) + wide_t'(ir);
    s = s <<< GUARD;
    return s[MAC_W-1:0];
  endfunction

  // Phase 2: far color in fixed point minus base, optional fraction drop
  function automatic wide_t diff_far(
      input logic signed [FAR_W-1:0] far, input logic signed [MAC_W-1:0] base,
      input logic sf);
    wide_t d;
    d = (wide_t'(far) <<< FRAC) - wide_t'(base);
    return sf ? (d >>> FRAC) : d;
  endfunction

  // Phase 3: difference times factor added back onto base
  function automatic logic signed [MAC_W-1:0] mac_blend(
      input logic signed [IR_W-1:0] ir, input logic signed [IR_W-1:0] f,
      input logic signed [MAC_W-1:0] base, input logic sf);
    wide_t p;
    p = wide_t'(ir) * wide_t'(f) + wide_t'(base);
    if (sf) p = p >>> FRAC;
    return p[MAC_W-1:0];
  endfunction

  function automatic ir_clamp_t clamp_ir(input wide_t v, input logic floor_zero);
    ir_clamp_t r;
    wide_t lo;
    lo = floor_zero ? wide_t'(0) : IR_MIN;
    r.sat = 1'b0;
    if (v > IR_MAX) begin
      r.val = IR_MAX[IR_W-1:0]; r.sat = 1'b1;
    end else if (v < lo) begin
      r.val = lo[IR_W-1:0]; r.sat = 1'b1;
    end else begin
      r.val = v[IR_W-1:0];
    end
    return r;
  endfunction

  function automatic col_clamp_t col_of(input logic signed [MAC_W-1:0] mac);
    col_clamp_t r;
    wide_t v;
    v = wide_t'(mac) >>> GUARD;
    r.sat = 1'b0;
    if (v > COL_MAX) begin
      r.val = '1; r.sat = 1'b1;
    end else if (v < 0) begin
      r.val = '0; r.sat = 1'b1;
    end else begin
      r.val = v[COL_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/dq_seq.sv
module dq_seq
  import dq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ph1_evt,
  output logic ph2_evt,
  output logic ph3_evt,
  output logic push_evt,
  output logic busy,
  output logic done
);
  phase_t st_q;

  assign ph1_evt  = (st_q == ST_IDLE) && start;
  assign ph2_evt  = (st_q == ST_DIFF);
  assign ph3_evt  = (st_q == ST_BLEND);
  assign push_evt = (st_q == ST_PUSH);
  assign busy     = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= push_evt;
      case (st_q)
        ST_IDLE:  if (start) st_q <= ST_DIFF;
        ST_DIFF:  st_q <= ST_BLEND;
        ST_BLEND: st_q <= ST_PUSH;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph1_evt, ph2_evt, ph3_evt, push_evt}));
  // R7
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_evt |=> ph2_evt);
  // R7
  blend_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_evt |=> ph3_evt);
  // R7
  push_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> done);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !push_evt) |=> busy);
endmodule

// File: rtl/dq_lane.sv
module dq_lane
  import dq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ph1_evt,
  input  logic                    ph2_evt,
  input  logic                    ph3_evt,
  input  logic                    push_evt,
  input  logic [COL_W-1:0]        c_in,
  input  logic signed [IR_W-1:0]  ir_in,
  input  logic signed [FAR_W-1:0] far_in,
  input  logic signed [IR_W-1:0]  factor_in,
  input  logic                    sf,
  input  logic                    lm,
  output logic signed [IR_W-1:0]  ir_out,
  output logic [COL_W-1:0]        col_out,
  output logic                    ir_sat,
  output logic                    col_sat,
  output logic                    col_sat_nxt
);
  logic signed [MAC_W-1:0] base_q, mac_q, base_n, mac_n;
  logic signed [IR_W-1:0]  ir_q;
  logic [COL_W-1:0]        col_q;
  logic                    ir_sat_q, col_sat_q;
  ir_clamp_t               diff_c, blend_c;
  col_clamp_t              col_c;

  always_comb begin
    base_n  = base_acc(c_in, ir_in);
    diff_c  = clamp_ir(diff_far(far_in, base_q, sf), 1'b0);
    mac_n   = mac_blend(ir_q, factor_in, base_q, sf);
    blend_c = clamp_ir(wide_t'(mac_n), lm);
    col_c   = col_of(mac_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      mac_q     <= '0;
      ir_q      <= '0;
      col_q     <= '0;
      ir_sat_q  <= 1'b0;
      col_sat_q <= 1'b0;
    end else begin
      if (ph1_evt) begin
        base_q    <= base_n;
        ir_sat_q  <= 1'b0;
        col_sat_q <= 1'b0;
      end
      if (ph2_evt) begin
        ir_q     <= diff_c.val;
        ir_sat_q <= diff_c.sat;
      end
      if (ph3_evt) begin
        mac_q    <= mac_n;
        ir_q     <= blend_c.val;
        ir_sat_q <= ir_sat_q | blend_c.sat;
      end
      if (push_evt) begin
        col_q     <= col_c.val;
        col_sat_q <= col_c.sat;
      end
    end
  end

  assign ir_out      = ir_q;
  assign col_out     = col_q;
  assign ir_sat      = ir_sat_q;
  assign col_sat     = col_sat_q;
  assign col_sat_nxt = col_c.sat;

  // R4
  low_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph3_evt && lm) |=> !ir_q[IR_W-1]);
  // R5
  col_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_sat_q |-> (col_q == '0 || col_q == '1));
endmodule

// File: rtl/dq_interp.sv
module dq_interp
  import dq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [31:0]            color_in,
  input  logic signed [15:0]     ir_x,
  input  logic signed [15:0]     ir_y,
  input  logic signed [15:0]     ir_z,
  input  logic signed [31:0]     far_r,
  input  logic signed [31:0]     far_g,
  input  logic signed [31:0]     far_b,
  input  logic signed [15:0]     factor,
  input  logic                   sf,
  input  logic                   lm,
  output logic                   busy,
  output logic                   done,
  output logic [31:0]            color_out,
  output logic signed [15:0]     res_x,
  output logic signed [15:0]     res_y,
  output logic signed [15:0]     res_z,
  output logic [6:0]             flags
);
  localparam int CODE_LSB = LANES * COL_W;

  logic ph1_evt, ph2_evt, ph3_evt, push_evt;
  logic signed [IR_W-1:0]  ir_arr  [LANES];
  logic signed [FAR_W-1:0] far_arr [LANES];
  logic signed [FAR_W-1:0] far_q   [LANES];
  logic signed [IR_W-1:0]  res_arr [LANES];
  logic [COL_W-1:0]        col_arr [LANES];
  logic [LANES-1:0]        ir_sat, col_sat, col_sat_nxt;
  logic signed [IR_W-1:0]  factor_q;
  logic                    sf_q, lm_q, err_q;
  logic [COL_W-1:0]        code_q;

  assign ir_arr[0]  = ir_x;
  assign ir_arr[1]  = ir_y;
  assign ir_arr[2]  = ir_z;
  assign far_arr[0] = far_r;
  assign far_arr[1] = far_g;
  assign far_arr[2] = far_b;

  dq_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ph1_evt(ph1_evt), .ph2_evt(ph2_evt), .ph3_evt(ph3_evt),
    .push_evt(push_evt), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      factor_q <= '0;
      sf_q     <= 1'b0;
      lm_q     <= 1'b0;
      code_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (ph1_evt) begin
        factor_q <= factor;
        sf_q     <= sf;
        lm_q     <= lm;
        err_q    <= 1'b0;
      end
      if (push_evt) begin
        code_q <= color_in_code_q;
        err_q  <= |{ir_sat, col_sat_nxt};
      end
    end
  end

  logic [COL_W-1:0] color_in_code_q;
  always_ff @(posedge clk) begin
    if (!rst_n) color_in_code_q <= '0;
    else if (ph1_evt) color_in_code_q <= color_in[CODE_LSB +: COL_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) far_q[g] <= '0;
      else if (ph1_evt) far_q[g] <= far_arr[g];
    end

    dq_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .ph1_evt(ph1_evt), .ph2_evt(ph2_evt), .ph3_evt(ph3_evt), .push_evt(push_evt),
      .c_in(color_in[g*COL_W +: COL_W]), .ir_in(ir_arr[g]),
      .far_in(far_q[g]), .factor_in(factor_q), .sf(sf_q), .lm(lm_q),
      .ir_out(res_arr[g]), .col_out(col_arr[g]),
      .ir_sat(ir_sat[g]), .col_sat(col_sat[g]), .col_sat_nxt(col_sat_nxt[g])
    );

    assign color_out[g*COL_W +: COL_W] = col_arr[g];
  end

  assign color_out[CODE_LSB +: COL_W] = code_q;
  assign res_x = res_arr[0];
  assign res_y = res_arr[1];
  assign res_z = res_arr[2];
  assign flags = {err_q, col_sat, ir_sat};

  // R6
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph1_evt |=> (flags == '0));
  // R6
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[6] == |flags[5:0]));
endmodule

// File: tb/test_dq_interp.sv
`timescale 1ns/1ps
module test_dq_interp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] color_in = '0;
  logic signed [15:0] ir_x = '0, ir_y = '0, ir_z = '0, factor = '0;
  logic signed [31:0] far_r = '0, far_g = '0, far_b = '0;
  logic sf = 1'b0, lm = 1'b0;
  logic busy, done;
  logic [31:0] color_out;
  logic signed [15:0] res_x, res_y, res_z;
  logic [6:0] flags;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  dq_interp i_dq_interp (
    .clk(clk), .rst_n(rst_n), .start(start), .color_in(color_in),
    .ir_x(ir_x), .ir_y(ir_y), .ir_z(ir_z),
    .far_r(far_r), .far_g(far_g), .far_b(far_b),
    .factor(factor), .sf(sf), .lm(lm),
    .busy(busy), .done(done), .color_out(color_out),
    .res_x(res_x), .res_y(res_y), .res_z(res_z), .flags(flags)
  );

  typedef struct packed {
    logic [31:0]        color;
    logic signed [15:0] ix, iy, iz;
    logic signed [31:0] fr, fg, fb;
    logic signed [15:0] fac;
    logic               sf, lm;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h11804020, 16'sd100, 16'sd200, -16'sd50, 32'sd300, 32'sd50, 32'sd0,
      16'sh0800, 1'b1, 1'b0},
    '{32'hA5FFFF00, 16'sd0, 16'sd10, 16'sd20, 32'sd1000, -32'sd1000, 32'sd7,
      16'sh1000, 1'b0, 1'b0},
    '{32'h00102030, -16'sd500, -16'sd600, 16'sd0, -32'sd10, 32'sd0, 32'sd2,
      16'sh0C00, 1'b1, 1'b1},
    '{32'h7F0A0B0C, 16'sd5, 16'sd6, 16'sd7, 32'sd20, 32'sd40, 32'sd80,
      -16'sh0400, 1'b1, 1'b0},
    '{32'h3CC8641E, 16'sd10, 16'sd20, 16'sd30, 32'sd0, 32'sd0, 32'sd0,
      16'sd0, 1'b1, 1'b0},
    '{32'hFF000000, 16'sh8000, 16'sd32767, 16'sd0, 32'sh80000000, 32'sh7FFFFFFF,
      32'sd12345, 16'sh8000, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
               req, what, act, act, exp, exp);
    end
  endtask

  // Independent restatement of one channel's three phases and push
  task automatic model_lane(input longint c, input longint ir, input longint far,
                            input longint f, input bit s, input bit l,
                            output longint ir_res, output longint col,
                            output bit irsat, output bit colsat);
    longint b, d, m, lo, cc;
    b = (c + ir) * 16;
    d = far * 4096 - b;
    if (s) d = d >>> 12;
    irsat = 1'b0;
    if (d > 32767) begin d = 32767; irsat = 1'b1; end
    else if (d < -32768) begin d = -32768; irsat = 1'b1; end
    m = d * f + b;
    if (s) m = m >>> 12;
    m = longint'(int'(m));
    lo = l ? 0 : -32768;
    ir_res = m;
    if (ir_res > 32767) begin ir_res = 32767; irsat = 1'b1; end
    else if (ir_res < lo) begin ir_res = lo; irsat = 1'b1; end
    cc = m >>> 4;
    colsat = 1'b0;
    if (cc > 255) begin cc = 255; colsat = 1'b1; end
    else if (cc < 0) begin cc = 0; colsat = 1'b1; end
    col = cc;
  endtask

  task automatic expect_vec(input vec_t v, output logic [31:0] ecol,
                            output longint eir [3], output logic [6:0] eflags);
    longint colv;
    bit is, cs;
    longint irv [3];
    longint farv [3];
    irv  = '{longint'(v.ix), longint'(v.iy), longint'(v.iz)};
    farv = '{longint'(v.fr), longint'(v.fg), longint'(v.fb)};
    ecol = {v.color[31:24], 24'h0};
    eflags = '0;
    for (int ch = 0; ch < 3; ch++) begin
      model_lane(longint'(v.color[ch*8 +: 8]), irv[ch], farv[ch], longint'(v.fac),
                 v.sf, v.lm, eir[ch], colv, is, cs);
      ecol[ch*8 +: 8] = colv[7:0];
      eflags[ch] = is;
      eflags[3+ch] = cs;
    end
    eflags[6] = |eflags[5:0];
  endtask

  task automatic drive(input vec_t v);
    color_in = v.color; ir_x = v.ix; ir_y = v.iy; ir_z = v.iz;
    far_r = v.fr; far_g = v.fg; far_b = v.fb; factor = v.fac;
    sf = v.sf; lm = v.lm;
  endtask

  task automatic scramble();
    color_in = 32'hDEADBEEF; ir_x = -16'sd7; ir_y = 16'sd9; ir_z = 16'sd1234;
    far_r = 32'sd99999; far_g = -32'sd5; far_b = 32'sd77; factor = 16'sh7FFF;
    sf = ~sf; lm = ~lm;
  endtask

  task automatic check_results(input vec_t v, input string tag);
    logic [31:0] ecol;
    longint eir [3];
    logic [6:0] ef;
    expect_vec(v, ecol, eir, ef);
    // R5 packed color with code byte; R2 base feeds all of it
    chk(color_out == ecol, "R5/R2", {tag, " color_out"}, longint'(color_out), longint'(ecol));
    // R3 and R4 final intermediates
    chk(longint'(res_x) == eir[0], "R4/R3", {tag, " res_x"}, longint'(res_x), eir[0]);
    chk(longint'(res_y) == eir[1], "R4/R3", {tag, " res_y"}, longint'(res_y), eir[1]);
    chk(longint'(res_z) == eir[2], "R4/R3", {tag, " res_z"}, longint'(res_z), eir[2]);
    // R6 flag layout
    chk(flags == ef, "R6", {tag, " flags"}, longint'(flags), longint'(ef));
  endtask

  // Full operation with timing checks; inputs scrambled after acceptance (R8)
  task automatic run_vec(input vec_t v, input string tag, input bit mid_start);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    scramble();
    chk(busy == 1'b1, "R7", {tag, " busy after accept"}, longint'(busy), 1);
    if (mid_start) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7", {tag, " done early"}, longint'(done), 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", {tag, " done early 2"}, longint'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R7", {tag, " done at fourth edge"}, longint'(done), 1);
    chk(busy == 1'b0, "R7", {tag, " busy released"}, longint'(busy), 0);
    check_results(v, tag);
    @(negedge clk);
    chk(done == 1'b0, "R7", {tag, " done one cycle"}, longint'(done), 0);
    chk(busy == 1'b0, "R8", {tag, " no extra operation"}, longint'(busy), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", longint'(busy), 0);
    chk(done == 1'b0, "R1", "done", longint'(done), 0);
    chk(color_out == 32'h0, "R1", "color_out", longint'(color_out), 0);
    chk(flags == 7'h0, "R1", "flags", longint'(flags), 0);
    chk(res_x == 16'sd0 && res_y == 16'sd0 && res_z == 16'sd0, "R1", "res",
        longint'(res_x), 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], $sformatf("vec%0d", i), 1'b0);
    end

    // R8: start while busy is ignored, results belong to the first operation
    run_vec(VECS[0], "r8_midstart", 1'b1);

    // R6: flags from a saturating run clear on the next accepted operation
    run_vec(VECS[1], "r6_sat", 1'b0);
    chk(flags[6] == 1'b1, "R6", "summary after saturation", longint'(flags[6]), 1);
    run_vec(VECS[4], "r6_clear", 1'b0);

    // R3: lm has no effect in phase 2 (same stimulus, lm differs)
    begin
      vec_t a;
      a = VECS[1];
      a.lm = 1'b1;
      run_vec(a, "r3_lm", 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule